// File: doc/BRIEF.md
# Pipelined Burst Read Master

This block reads one contiguous region of external memory through a memory-mapped port that uses a waitrequest / readdatavalid handshake. A one-cycle `start` pulse gives a byte base address and a word count. The block cuts the region into bursts of `BURST_LEN` words; only the final burst may be shorter. It presents each burst as a single read command. The next command goes out as soon as the previous one is taken, so several bursts can be outstanding while their data is still coming back.

Returned words are pushed into a local receive buffer. They leave the block on a plain valid/ready word stream, in address order. Two limits gate every command. The first is a cap on the number of bursts in flight. The second is a word budget that covers both outstanding words and buffered words, so the buffer can never overflow. When the last word has come back, the block raises `done` for one cycle.

Top module: `burst_reader`

## Requirements
- R1: While reset is held and after it is released, `avm_read`, `done`, `busy` and `out_valid` are low.
- R2: The memory port takes a command only in a cycle where `avm_read` is high and `avm_waitrequest` is low. While `avm_read` is high and `avm_waitrequest` is high, `avm_read`, `avm_address` and `avm_burstcount` hold their values into the next cycle.
- R3: The block issues ceil(words / `BURST_LEN`) commands for one job, in ascending address order. The first command uses the base address, and each later address is the previous one plus its burst count times `DATA_W`/8 bytes. Every burst carries `BURST_LEN` words except the last, which carries the remainder. `BURST_LEN` must not exceed 2^(`BCNT_W`-1).
- R4: When both limits allow it, the next command is presented in the cycle right after the previous one is taken, so `avm_read` stays high with no idle cycle.
- R5: A command counts as in flight from the cycle it is presented until its last word returns. The number of bursts in flight never exceeds `MAX_INFLIGHT` (at most 63), and a long-latency memory drives it up to that limit.
- R6: Words in flight plus words held in the receive buffer never exceed `FIFO_DEPTH`. A command is held back until its whole burst fits in that budget.
- R7: A word of `avm_readdata` is captured only in cycles where `avm_readdatavalid` is high, whatever `avm_read` and `avm_waitrequest` are doing in that cycle.
- R8: Captured words appear on `out_data` in address order. A word leaves the buffer on a cycle with `out_valid` and `out_ready` both high, and `out_valid` and `out_data` stay unchanged while `out_ready` is low.
- R9: `done` is high for exactly the one cycle after the cycle that carried the job's last `avm_readdatavalid`. In that same cycle `busy` is low and no burst is in flight.
- R10: A `start` pulse that arrives while `busy` is high has no effect. A `start` with a word count of zero issues no command, and raises `done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle job request |
| start_addr | input | ADDR_W | Byte base address of the region |
| start_words | input | LEN_W | Number of words to read |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle pulse when the job's last word has arrived |
| avm_address | output | ADDR_W | Byte address of the presented burst |
| avm_read | output | 1 | Read command presented |
| avm_burstcount | output | BCNT_W | Words in the presented burst |
| avm_waitrequest | input | 1 | Memory cannot take the command this cycle |
| avm_readdata | input | DATA_W | Returned word |
| avm_readdatavalid | input | 1 | `avm_readdata` carries a valid word |
| out_valid | output | 1 | Stream word available |
| out_data | output | DATA_W | Stream word |
| out_ready | input | 1 | Consumer takes the stream word |

## Verification
The assertions assume that the memory returns exactly the words it has accepted, in the order it accepted them, and never raises `avm_readdatavalid` without an accepted command behind it. The bench memory model meets this by design. It queues every accepted burst, holds back each word for a set latency, and releases words only from the head of that queue. Outside those cycles it drives junk on `avm_readdata`. Its waitrequest, readdatavalid-gap and `out_ready` patterns are deterministic functions of the cycle count, so each sweep point is reproducible.

// File: rtl/brd_pkg.sv
package brd_pkg;

    // Command generator phases
    typedef enum logic [1:0] {
        CG_IDLE  = 2'd0,   // no job, nothing to issue
        CG_RUN   = 2'd1,   // words left to request
        CG_FLUSH = 2'd2    // all commands issued, last one may still be presented
    } cg_state_e;

endpackage

// File: rtl/brd_cmd_gen.sv
module brd_cmd_gen
    import brd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int BCNT_W     = 4,
    parameter int BURST_LEN  = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_take,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_words,
    input  logic              can_issue,
    input  logic              waitreq,
    output logic [BCNT_W-1:0] next_len,
    output logic              issue,
    output logic              cmd_read,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BCNT_W-1:0] cmd_bcnt
);

    localparam logic [LEN_W-1:0]  BL_L   = LEN_W'(BURST_LEN);
    localparam logic [ADDR_W-1:0] UNIT_L = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        cg_state_e         state;
        logic              read;
        logic [ADDR_W-1:0] addr;
        logic [BCNT_W-1:0] bcnt;
        logic [ADDR_W-1:0] plan_addr;
        logic [LEN_W-1:0]  remain;
    } cg_t;

    cg_t  q, d;
    logic taken;
    logic slot_free;

    // Length of the next burst: full length or the tail remainder
    always_comb begin
        if (q.remain > BL_L) begin
            next_len = BCNT_W'(BURST_LEN);
        end else begin
            next_len = BCNT_W'(q.remain);
        end
    end

    always_comb begin
        d         = q;
        issue     = 1'b0;
        taken     = q.read && !waitreq;
        slot_free = !q.read || taken;
        if (taken) begin
            d.read = 1'b0;
        end
        unique case (q.state)
            CG_IDLE: begin
                if (start_take && (start_words != '0)) begin
                    d.state     = CG_RUN;
                    d.plan_addr = start_addr;
                    d.remain    = start_words;
                end
            end
            CG_RUN: begin
                if (slot_free && can_issue) begin
                    issue       = 1'b1;
                    d.read      = 1'b1;
                    d.addr      = q.plan_addr;
                    d.bcnt      = next_len;
                    d.plan_addr = q.plan_addr + ADDR_W'(next_len) * UNIT_L;
                    d.remain    = q.remain - LEN_W'(next_len);
                    if (q.remain == LEN_W'(next_len)) begin
                        d.state = CG_FLUSH;
                    end
                end
            end
            CG_FLUSH: begin
                if (!d.read) begin
                    d.state = CG_IDLE;
                end
            end
            default: d.state = CG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_read = q.read;
    assign cmd_addr = q.addr;
    assign cmd_bcnt = q.bcnt;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && waitreq) |=> (cmd_read && $stable(cmd_addr) && $stable(cmd_bcnt))); // R2

    AST_BCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_read |-> ((cmd_bcnt != '0) && (int'(cmd_bcnt) <= BURST_LEN))); // R3

endmodule

// File: rtl/brd_flight_trk.sv
module brd_flight_trk #(
    parameter int LEN_W        = 16,
    parameter int BCNT_W       = 4,
    parameter int BURST_LEN    = 8,
    parameter int MAX_INFLIGHT = 8,
    parameter int FIFO_DEPTH   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_take,
    input  logic [LEN_W-1:0]  start_words,
    input  logic              issue,
    input  logic [BCNT_W-1:0] issue_len,
    input  logic              rvalid,
    input  logic              pop,
    output logic              can_issue,
    output logic              busy,
    output logic              done
);

    localparam int BW  = $clog2(MAX_INFLIGHT + 1);
    localparam int RW  = $clog2(FIFO_DEPTH + 1);
    localparam int BTW = $clog2(BURST_LEN + 1);
    localparam logic [BTW-1:0] LAST_BEAT = BTW'(BURST_LEN - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [BW-1:0]    bursts;
        logic [RW-1:0]    resv;
        logic [BTW-1:0]   beat;
        logic [LEN_W-1:0] rsp_left;
    } trk_t;

    trk_t q, d;
    logic take;
    logic burst_end;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        take      = rvalid && q.busy;
        burst_end = 1'b0;
        if (start_take) begin
            d.busy     = (start_words != '0);
            d.done     = (start_words == '0);
            d.rsp_left = start_words;
            d.beat     = '0;
        end else if (take) begin
            d.rsp_left = q.rsp_left - 1'b1;
            if ((q.beat == LAST_BEAT) || (q.rsp_left == LEN_W'(1))) begin
                burst_end = 1'b1;
                d.beat    = '0;
            end else begin
                d.beat = q.beat + 1'b1;
            end
            if (q.rsp_left == LEN_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
        d.bursts = q.bursts + BW'(issue) - BW'(burst_end);
        d.resv   = q.resv + (issue ? RW'(issue_len) : RW'(0)) - RW'(pop);
    end

    // Both budgets are judged on registered counts: conservative by one cycle
    always_comb begin
        can_issue = (int'(q.bursts) < MAX_INFLIGHT)
                 && ((int'(q.resv) + int'(issue_len)) <= FIFO_DEPTH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy = q.busy;
    assign done = q.done;

    AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q.bursts) <= MAX_INFLIGHT); // R5

    AST_END_HAS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |-> (q.bursts != '0 || issue)); // R5

    AST_RESV_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q.resv) <= FIFO_DEPTH); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && q.bursts == '0)); // R9

endmodule

// File: rtl/brd_rx_fifo.sv
module brd_rx_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } ff_t;

    ff_t q, d;
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        d = q;
        if (push) begin
            d.wr = (q.wr == PTR_LAST) ? '0 : q.wr + 1'b1;
        end
        if (pop) begin
            d.rd = (q.rd == PTR_LAST) ? '0 : q.rd + 1'b1;
        end
        d.cnt = q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[q.wr] <= wdata;
        end
    end

    assign out_valid = (q.cnt != '0);
    assign out_data  = mem_q[q.rd];

    AST_FIFO_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ((int'(q.cnt) < DEPTH) || pop)); // R6

    AST_FIFO_NO_UNF: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> out_valid); // R8

endmodule

// File: rtl/burst_reader.sv
module burst_reader #(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter int LEN_W        = 16,
    parameter int BCNT_W       = 4,
    parameter int BURST_LEN    = 8,
    parameter int MAX_INFLIGHT = 8,
    parameter int FIFO_DEPTH   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_words,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] avm_address,
    output logic              avm_read,
    output logic [BCNT_W-1:0] avm_burstcount,
    input  logic              avm_waitrequest,
    input  logic [DATA_W-1:0] avm_readdata,
    input  logic              avm_readdatavalid,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);

    localparam int WORD_BYTES = DATA_W / 8;

    if (BURST_LEN > (1 << (BCNT_W - 1))) begin : g_bad_burst
        $error("burst_reader: BURST_LEN exceeds the burst count field");
    end
    if ((MAX_INFLIGHT < 1) || (MAX_INFLIGHT > 63)) begin : g_bad_inflight
        $error("burst_reader: MAX_INFLIGHT must be 1 to 63");
    end
    if (FIFO_DEPTH < BURST_LEN) begin : g_bad_depth
        $error("burst_reader: FIFO_DEPTH must hold one full burst");
    end

    logic              start_take;
    logic              can_issue;
    logic              issue;
    logic [BCNT_W-1:0] next_len;
    logic              pop;

    assign start_take = start && !busy;
    assign pop        = out_valid && out_ready;

    brd_cmd_gen #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .BCNT_W     (BCNT_W),
        .BURST_LEN  (BURST_LEN),
        .WORD_BYTES (WORD_BYTES)
    ) i_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_take  (start_take),
        .start_addr  (start_addr),
        .start_words (start_words),
        .can_issue   (can_issue),
        .waitreq     (avm_waitrequest),
        .next_len    (next_len),
        .issue       (issue),
        .cmd_read    (avm_read),
        .cmd_addr    (avm_address),
        .cmd_bcnt    (avm_burstcount)
    );

    brd_flight_trk #(
        .LEN_W        (LEN_W),
        .BCNT_W       (BCNT_W),
        .BURST_LEN    (BURST_LEN),
        .MAX_INFLIGHT (MAX_INFLIGHT),
        .FIFO_DEPTH   (FIFO_DEPTH)
    ) i_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_take  (start_take),
        .start_words (start_words),
        .issue       (issue),
        .issue_len   (next_len),
        .rvalid      (avm_readdatavalid),
        .pop         (pop),
        .can_issue   (can_issue),
        .busy        (busy),
        .done        (done)
    );

    brd_rx_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (FIFO_DEPTH)
    ) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (avm_readdatavalid),
        .wdata     (avm_readdata),
        .pop       (pop),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !avm_read); // R10

endmodule

// File: tb/test_burst_reader.sv
module test_burst_reader;

    localparam int AW = 32, DW = 32, LW = 12, BCW = 3, BL = 4, MI = 3, FD = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [LW-1:0] start_words = '0;
    logic          busy, done;
    logic [AW-1:0] avm_address;
    logic          avm_read;
    logic [BCW-1:0] avm_burstcount;
    logic          avm_waitrequest = 1'b0;
    logic [DW-1:0] avm_readdata = '0;
    logic          avm_readdatavalid = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_ready = 1'b0;

    always #5 clk = ~clk;

    burst_reader #(
        .ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .BCNT_W(BCW),
        .BURST_LEN(BL), .MAX_INFLIGHT(MI), .FIFO_DEPTH(FD)
    ) i_burst_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_words(start_words), .busy(busy), .done(done),
        .avm_address(avm_address), .avm_read(avm_read), .avm_burstcount(avm_burstcount),
        .avm_waitrequest(avm_waitrequest), .avm_readdata(avm_readdata),
        .avm_readdatavalid(avm_readdatavalid), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready)
    );

    int n_checks = 0;
    int n_errs   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    function automatic bit gate(input int mode, input int c);
        case (mode)
            0:       return 1'b1;
            1:       return (c % 2) == 0;
            2:       return ((c * 7 + 3) % 5) < 2;
            default: return (c % 9) == 0;
        endcase
    endfunction

    // memory model and monitor state
    int cyc = 0;
    bit job_on = 0;
    logic [31:0] job_base, exp_addr;
    int job_words, exp_remain, rx_words, pop_words, cmd_cnt;
    int acc_b, fin_b, acc_w, max_inf, max_res;
    int wmode = 0, rmode = 0, omode = 0, lat = 1;
    int exp_done_cyc = -1, acc_cyc0, acc_cyc1;
    bit done_seen = 0;
    bit prev_stall = 0;
    logic [31:0] prev_addr;
    logic [BCW-1:0] prev_bcnt;
    logic [31:0] qd [64];
    int          qr [64];
    bit          ql [64];
    int qh = 0, qt = 0;

    always @(negedge clk) begin : model
        int inf, res, el;
        bit wr, rv;
        logic [31:0] e;
        if (rst_n) begin
            cyc++;
            if (start && !job_on) begin
                job_on = 1; job_base = start_addr; exp_addr = start_addr;
                job_words = int'(start_words); exp_remain = int'(start_words);
                rx_words = 0; pop_words = 0; cmd_cnt = 0; done_seen = 0;
                max_inf = 0; max_res = 0; acc_b = 0; fin_b = 0; acc_w = 0;
                acc_cyc0 = -1; acc_cyc1 = -1;
                exp_done_cyc = (start_words == '0) ? cyc : -1;
            end
            if (done) begin
                check(cyc == exp_done_cyc, "R9", "done cycle", cyc, exp_done_cyc);
                check(!busy, "R9", "busy low at done", busy, 0);
                done_seen = 1; job_on = 0; exp_done_cyc = -1;
            end else if (exp_done_cyc == cyc) begin
                check(0, "R9", "done missing", 0, 1);
                exp_done_cyc = -1;
            end
            inf = acc_b - fin_b + (avm_read ? 1 : 0);
            res = acc_w - pop_words + (avm_read ? int'(avm_burstcount) : 0);
            if (inf > max_inf) max_inf = inf;
            if (res > max_res) max_res = res;
            if (prev_stall) begin
                check(avm_read && avm_address == prev_addr && avm_burstcount == prev_bcnt,
                      "R2", "command held under waitrequest", avm_address, prev_addr);
            end
            wr = !gate(wmode, cyc);
            avm_waitrequest = wr;
            prev_stall = avm_read && wr;
            prev_addr  = avm_address;
            prev_bcnt  = avm_burstcount;
            if (avm_read && !wr) begin
                el = (exp_remain > BL) ? BL : exp_remain;
                check(avm_address == exp_addr, "R3", "burst address", avm_address, exp_addr);
                check(int'(avm_burstcount) == el, "R3", "burst length", avm_burstcount, el);
                if (cmd_cnt == 0) acc_cyc0 = cyc;
                if (cmd_cnt == 1) acc_cyc1 = cyc;
                for (int k = 0; k < int'(avm_burstcount); k++) begin
                    qd[qt] = word_of(avm_address + 32'(4 * k));
                    qr[qt] = cyc + lat;
                    ql[qt] = (k == int'(avm_burstcount) - 1);
                    qt = (qt + 1) % 64;
                end
                exp_addr = exp_addr + 32'(el * 4);
                exp_remain = exp_remain - el;
                cmd_cnt++; acc_b++; acc_w += int'(avm_burstcount);
            end
            out_ready = gate(omode, cyc);
            if (out_valid && out_ready) begin
                e = word_of(job_base + 32'(4 * pop_words));
                check(out_data == e, "R7 R8", "stream word", out_data, e);
                pop_words++;
            end
            rv = (qh != qt) && (qr[qh] <= cyc) && gate(rmode, cyc);
            if (rv) begin
                avm_readdatavalid = 1'b1;
                avm_readdata = qd[qh];
                if (ql[qh]) fin_b++;
                qh = (qh + 1) % 64;
                rx_words++;
                if (rx_words == job_words) exp_done_cyc = cyc + 1;
            end else begin
                avm_readdatavalid = 1'b0;
                avm_readdata = 32'hBAD0_0000 ^ 32'(cyc);
            end
        end
    end

    task automatic run_job(input logic [31:0] addr, input int words, input int w,
                           input int r, input int o, input int l, input bit intrude);
        int t;
        @(negedge clk);
        #1;
        wmode = w; rmode = r; omode = o; lat = l;
        start_addr = addr; start_words = LW'(words); start = 1'b1;
        @(negedge clk);
        #1 start = 1'b0;
        if (intrude) begin
            repeat (3) @(negedge clk);
            #1;
            start_addr = 32'hDEAD_0000; start_words = LW'(5); start = 1'b1;
            @(negedge clk);
            #1 start = 1'b0;
        end
        t = 0;
        while (!(done_seen && pop_words == words) && t < 4000) begin
            @(negedge clk);
            t++;
        end
        check(t < 4000, "R9", "job completed", t, 4000);
        check(cmd_cnt == (words + BL - 1) / BL, "R3", "command count", cmd_cnt, (words + BL - 1) / BL);
        check(max_inf <= MI, "R5", "bursts in flight", max_inf, MI);
        check(max_res <= FD, "R6", "reserved words", max_res, FD);
        check(pop_words == words, "R8", "words delivered", pop_words, words);
        if (words == 0) check(cmd_cnt == 0, "R10", "zero-word job issues nothing", cmd_cnt, 0);
        if (intrude) check(cmd_cnt == (words + BL - 1) / BL, "R10", "start during busy ignored",
                           cmd_cnt, (words + BL - 1) / BL);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!avm_read, "R1", "read in reset", avm_read, 0);
        check(!done && !busy, "R1", "done/busy in reset", {done, busy}, 0);
        check(!out_valid, "R1", "out_valid in reset", out_valid, 0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!avm_read && !busy && !done && !out_valid, "R1", "idle after reset",
              {avm_read, busy, done, out_valid}, 0);

        for (int wd = 0; wd < 14; wd++) begin
            for (int c = 0; c < 3; c++) begin
                case (c)
                    0: run_job(32'h0001_0000 + 32'(wd * 1024), wd, 0, 0, 0, 1, 1'b0);
                    1: run_job(32'h0001_0040 + 32'(wd * 1024), wd, 1, 1, 1, 3, wd == 13);
                    default: run_job(32'h0001_0080 + 32'(wd * 1024), wd, 2, 2, 3, 5, 1'b0);
                endcase
            end
        end

        // back-to-back commands with an idle memory port
        run_job(32'h0002_0000, 8, 0, 0, 0, 6, 1'b0);
        check(acc_cyc1 == acc_cyc0 + 1, "R4", "second command right after first", acc_cyc1, acc_cyc0 + 1);

        // long latency: burst cap is reached
        run_job(32'h0003_0000, 24, 0, 0, 0, 20, 1'b0);
        check(max_inf == MI, "R5", "burst cap reached", max_inf, MI);

        // slow consumer: word budget is reached
        run_job(32'h0004_0000, 24, 0, 0, 3, 2, 1'b0);
        check(max_res == FD, "R6", "word budget reached", max_res, FD);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        #(150000 * 10);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule